// File: doc/BRIEF.md
# Conditional Block-Floating-Point Scaler

This block runs between stages of a radix-4 fixed-point FFT. After a stage has written its results back to the block buffer, a start pulse makes the scaler walk the buffer twice at most. Each buffer word packs one complex value: the real part in bits 31:16 and the imaginary part in bits 15:0, both 16-bit two's complement. The first pass reads every word once. It takes the magnitude of both halves and ORs them into a 32-bit accumulator. Once the pass ends, the two 16-bit halves of the accumulator are ORed into a single magnitude mask.

The data enters a stage with three guard bits, because one radix-4 stage can widen values by up to three bits. The scaler reads the worst-case growth from the highest set bit of the mask. If there was no growth, it finishes at once and the buffer is left untouched. If there was growth, a second pass rewrites every word with both halves shifted right arithmetically by the growth amount, and the shift is added to a running block exponent. The exponent only returns to zero when the block is reset, which the FFT does before each new transform.

The buffer is reached through a simple dual-port memory interface with a one-cycle read latency. Each pass handles one word per cycle.

Top module: `bfp_scaler`

## Requirements
- R1: While reset is asserted, and on leaving it, exp_o is 0, done_o is 0 and neither rd_en_o nor wr_en_o is high. A reset given after some blocks have been scaled returns exp_o to 0.
- R2: After a start pulse, the scan pass issues exactly blk_len_i reads, one per cycle, at addresses 0, 1, … blk_len_i−1 in that order. No write occurs during the scan.
- R3: Each word is split as real = bits 31:16 and imaginary = bits 15:0, and the magnitude of each half is taken. A half equal to −32768 counts as magnitude 0x8000. The magnitudes are ORed over the whole block and the two halves are then folded into one 16-bit mask.
- R4: Let p be the position of the highest set bit in the mask. The growth g is p−12 when p > 12, and 0 otherwise (including an all-zero mask). g never exceeds 3.
- R5: When g = 0, no write occurs, the buffer is unchanged, exp_o keeps its value, and done_o rises blk_len_i+2 clock edges after the edge that sampled start_i.
- R6: When g > 0, every word 0 … blk_len_i−1 is written exactly once, in address order. Each write goes to the address read one cycle earlier. Both halves are shifted right arithmetically by g (sign extended) and repacked with real in bits 31:16 and imaginary in bits 15:0.
- R7: When g > 0, exp_o increases by g, and the increase accumulates over successive blocks.
- R8: When g > 0, done_o rises 2·blk_len_i+3 edges after the start edge. done_o is always a single-cycle pulse.
- R9: A start pulse that arrives while a block is being processed has no effect: there are no extra reads or writes, and done_o timing and exp_o are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the block exponent |
| start_i | input | 1 | One-cycle pulse that starts the scaling of a block |
| blk_len_i | input | 9 | Number of words in the block (1…256), sampled with start_i |
| rd_en_o | output | 1 | Buffer read request |
| rd_addr_o | output | 8 | Buffer read address |
| rd_data_i | input | 32 | Read data, valid one cycle after the request |
| wr_en_o | output | 1 | Buffer write request |
| wr_addr_o | output | 8 | Buffer write address |
| wr_data_o | output | 32 | Rewritten word {real, imag} |
| exp_o | output | 8 | Accumulated block exponent |
| done_o | output | 1 | One-cycle pulse marking the end of a block |

## Verification
Every result has a fixed due cycle counted from the edge that samples start_i:
- read k is requested in the cycle after edge k;
- the word arrives one edge later;
- when a rewrite follows, the write of word k is presented in the cycle after edge blk_len_i+3+k;
- done_o is due after edge blk_len_i+2 when no rewrite is needed, and after edge 2·blk_len_i+3 when one is.

The bench samples between edges. It counts edges from start to done and compares the count with these formulas. A monitor pops the expected writes from a queue at the moment wr_en_o is seen, so both the order and the timing of the writes are checked, not just the final buffer contents.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DECIDE,
        ST_REWRITE,
        ST_DONE
    } bfp_state_e;
endpackage

// File: rtl/bfp_word_mag.sv
module bfp_word_mag #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word_i,
    output logic [2*HALF_W-1:0] mag_o
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] half_v;
        assign half_v = word_i[h*HALF_W +: HALF_W];
        // two's complement negate; the most negative code maps to its own bit pattern
        assign mag_o[h*HALF_W +: HALF_W] = half_v[HALF_W-1] ? (~half_v + 1'b1) : half_v;
    end
endmodule

// File: rtl/bfp_growth.sv
module bfp_growth #(
    parameter int HALF_W  = 16,
    parameter int GUARD   = 3,
    parameter int SHIFT_W = 2
) (
    input  logic [HALF_W-1:0]  mask_i,
    output logic [SHIFT_W-1:0] g_o
);
    localparam int KNEE = HALF_W - 1 - GUARD;

    int   pos;
    logic found;
    int   gi;

    always_comb begin
        pos   = 0;
        found = 1'b0;
        for (int i = 0; i < HALF_W; i++) begin
            if (mask_i[i]) begin
                pos   = i;
                found = 1'b1;
            end
        end
        gi = (found && pos > KNEE) ? pos - KNEE : 0;
        if (gi > GUARD) gi = GUARD;
        g_o = SHIFT_W'(gi);
    end

    always_comb begin
        assert_g_bounded_R4: assert (int'(g_o) <= GUARD);
        assert_g_zero_in_headroom_R4: assert ((mask_i[HALF_W-1 -: GUARD] != '0) || (g_o == '0));
    end
endmodule

// File: rtl/bfp_shift.sv
module bfp_shift #(
    parameter int HALF_W  = 16,
    parameter int SHIFT_W = 2
) (
    input  logic [2*HALF_W-1:0] word_i,
    input  logic [SHIFT_W-1:0]  sh_i,
    output logic [2*HALF_W-1:0] word_o
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic signed [HALF_W-1:0] in_v;
        logic signed [HALF_W-1:0] out_v;
        assign in_v  = word_i[h*HALF_W +: HALF_W];
        assign out_v = in_v >>> sh_i;
        assign word_o[h*HALF_W +: HALF_W] = out_v;

        always_comb begin
            assert_sign_kept_R6: assert (out_v[HALF_W-1] == in_v[HALF_W-1]);
        end
    end
endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler #(
    parameter int ADDR_W = 8,
    parameter int HALF_W = 16,
    parameter int GUARD  = 3,
    parameter int EXP_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [ADDR_W:0]       blk_len_i,
    output logic                  rd_en_o,
    output logic [ADDR_W-1:0]     rd_addr_o,
    input  logic [2*HALF_W-1:0]   rd_data_i,
    output logic                  wr_en_o,
    output logic [ADDR_W-1:0]     wr_addr_o,
    output logic [2*HALF_W-1:0]   wr_data_o,
    output logic [EXP_W-1:0]      exp_o,
    output logic                  done_o
);
    import bfp_pkg::*;

    localparam int WORD_W  = 2 * HALF_W;
    localparam int LEN_W   = ADDR_W + 1;
    localparam int SHIFT_W = $clog2(GUARD + 1);

    typedef struct packed {
        bfp_state_e          st;
        logic [LEN_W-1:0]    len;
        logic [LEN_W-1:0]    cnt;
        logic                vld;
        logic [ADDR_W-1:0]   tag;
        logic [WORD_W-1:0]   acc;
        logic [SHIFT_W-1:0]  sh;
        logic [EXP_W-1:0]    expo;
    } regs_t;

    regs_t q, d;

    logic [WORD_W-1:0]  mag_w;
    logic [HALF_W-1:0]  mask_w;
    logic [SHIFT_W-1:0] g_w;
    logic [WORD_W-1:0]  shifted_w;
    logic               rd_req;
    logic               last_w;

    bfp_word_mag #(.HALF_W(HALF_W)) u_mag (
        .word_i (rd_data_i),
        .mag_o  (mag_w)
    );

    assign mask_w = q.acc[WORD_W-1:HALF_W] | q.acc[HALF_W-1:0];

    bfp_growth #(.HALF_W(HALF_W), .GUARD(GUARD), .SHIFT_W(SHIFT_W)) u_growth (
        .mask_i (mask_w),
        .g_o    (g_w)
    );

    bfp_shift #(.HALF_W(HALF_W), .SHIFT_W(SHIFT_W)) u_shift (
        .word_i (rd_data_i),
        .sh_i   (q.sh),
        .word_o (shifted_w)
    );

    assign last_w = ({1'b0, q.tag} == (q.len - LEN_W'(1)));

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        rd_req = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.len = blk_len_i;
                    d.cnt = '0;
                    d.acc = '0;
                    d.st  = (blk_len_i == '0) ? ST_DONE : ST_SCAN;
                end
            end
            ST_SCAN, ST_REWRITE: begin
                if (q.cnt < q.len) begin
                    rd_req = 1'b1;
                    d.cnt  = q.cnt + LEN_W'(1);
                    d.vld  = 1'b1;
                    d.tag  = q.cnt[ADDR_W-1:0];
                end
                if (q.vld) begin
                    if (q.st == ST_SCAN) d.acc = q.acc | mag_w;
                    if (last_w) d.st = (q.st == ST_SCAN) ? ST_DECIDE : ST_DONE;
                end
            end
            ST_DECIDE: begin
                if (g_w == '0) begin
                    d.st = ST_DONE;
                end else begin
                    d.sh   = g_w;
                    d.expo = q.expo + EXP_W'(g_w);
                    d.cnt  = '0;
                    d.st   = ST_REWRITE;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_en_o   = rd_req;
    assign rd_addr_o = q.cnt[ADDR_W-1:0];
    assign wr_en_o   = q.vld && (q.st == ST_REWRITE);
    assign wr_addr_o = q.tag;
    assign wr_data_o = shifted_w;
    assign exp_o     = q.expo;
    assign done_o    = (q.st == ST_DONE);

    assert_exp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_o != $past(exp_o)) |-> ((exp_o - $past(exp_o)) <= EXP_W'(GUARD)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_wr_follows_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(rd_en_o) && (wr_addr_o == $past(rd_addr_o))));

    assert_no_rw_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && wr_en_o) |-> (rd_addr_o != wr_addr_o));

    assert_scan_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(exp_o) == exp_o && $past(done_o, 1) == 1'b0) |-> !wr_en_o);
endmodule

// File: tb/bfp_scaler_tb_top.sv
module bfp_scaler_tb_top;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  blk_len = '0;
    logic        rd_en, wr_en, done;
    logic [7:0]  rd_addr, wr_addr, expo;
    logic [31:0] rd_data = '0;
    logic [31:0] wr_data;

    logic [31:0] mem  [DEPTH];
    logic [31:0] save [DEPTH];

    typedef struct { int addr; logic [31:0] data; } item_t;
    item_t exp_q [$];

    int checks = 0, fails = 0;
    int rd_count = 0, wr_count = 0, cur_len = 1;
    int exp_model = 0;

    always #5 clk = ~clk;

    bfp_scaler dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_len_i(blk_len),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .exp_o(expo), .done_o(done)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: reads in order (R2), writes popped from the scoreboard (R6)
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            chk(int'(rd_addr) == (rd_count % cur_len), "R2", "read address", rd_addr, rd_count % cur_len);
            rd_count++;
        end
        if (rst_n && wr_en) begin
            wr_count++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected write", wr_addr, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(int'(wr_addr) == it.addr, "R6", "write address", wr_addr, it.addr);
                chk(wr_data == it.data, "R6", "write data", wr_data, it.data);
            end
        end
    end

    task automatic run_block(int len, string req, bit restart_mid);
        logic [31:0] accw;
        logic [15:0] mask;
        int p, g, n, want;
        accw = '0;
        for (int i = 0; i < len; i++) begin
            logic signed [15:0] re, im;
            re = mem[i][31:16];
            im = mem[i][15:0];
            accw[31:16] |= (re < 0) ? 16'(-re) : re;
            accw[15:0]  |= (im < 0) ? 16'(-im) : im;
            save[i] = mem[i];
        end
        mask = accw[31:16] | accw[15:0];
        p = -1;
        for (int b = 0; b < 16; b++) if (mask[b]) p = b;
        g = (p > 12) ? p - 12 : 0;
        if (g > 0) begin
            for (int i = 0; i < len; i++) begin
                logic signed [15:0] re, im;
                item_t it;
                re = save[i][31:16];
                im = save[i][15:0];
                it.addr = i;
                it.data = {16'(re >>> g), 16'(im >>> g)};
                exp_q.push_back(it);
            end
        end
        exp_model += g;
        rd_count = 0;
        wr_count = 0;
        cur_len  = len;
        @(negedge clk);
        start = 1'b1;
        blk_len = 9'(len);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = (restart_mid && n == 3);
        end
        start = 1'b0;
        want = (g > 0) ? 2 * len + 3 : len + 2;
        chk(n == want, (g > 0) ? "R8" : "R5", "done edge", n, want);
        chk(int'(expo) == (exp_model & 255), (g > 0) ? "R7" : "R5", "exponent", expo, exp_model & 255);
        chk(rd_count == ((g > 0) ? 2 * len : len), req, "read count", rd_count, (g > 0) ? 2 * len : len);
        chk(wr_count == ((g > 0) ? len : 0), "R6", "write count", wr_count, (g > 0) ? len : 0);
        chk(exp_q.size() == 0, "R6", "writes left", exp_q.size(), 0);
        if (g == 0) begin
            bit same = 1'b1;
            for (int i = 0; i < len; i++) if (mem[i] != save[i]) same = 1'b0;
            chk(same, "R5", "buffer untouched", same, 1);
        end
        @(negedge clk);
        chk(!done, "R8", "done single cycle", done, 0);
        exp_q.delete();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(expo == 0 && !done && !rd_en && !wr_en, "R1", "reset outputs", {expo, done, rd_en, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(expo == 0 && !done && !rd_en && !wr_en, "R1", "after reset", {expo, done, rd_en, wr_en}, 0);

        // R3 R5: all within headroom, including -4096 whose magnitude is bit 12
        for (int i = 0; i < 16; i++)
            mem[i] = {16'((i * 37) % 8191 - 4095), 16'(4095 - (i * 53) % 8191)};
        mem[3][31:16] = 16'hF000;
        run_block(16, "R3", 1'b0);

        // R6 R7: one imaginary value of 9000 gives growth 1
        for (int i = 0; i < 16; i++) mem[i] = {16'(i * 100 - 800), 16'(-i * 40)};
        mem[7][15:0] = 16'd9000;
        run_block(16, "R6", 1'b0);

        // R9: a stray start mid-scan; real -20000 gives growth 2
        for (int i = 0; i < 16; i++) mem[i] = {16'(i * 211 - 1600), 16'(-i * 97 + 700)};
        mem[15][31:16] = 16'(-20000);
        run_block(16, "R9", 1'b1);

        // R3 R4: most negative code counts as bit 15, growth 3, single word
        mem[0] = 32'h8000_0001;
        run_block(1, "R4", 1'b0);

        // R4: all-zero block, no growth
        for (int i = 0; i < 8; i++) mem[i] = '0;
        run_block(8, "R4", 1'b0);

        // R6: full-depth pseudo-random block
        begin
            int unsigned s = 32'h1234_5678;
            for (int i = 0; i < DEPTH; i++) begin
                int a, b;
                s = s * 1103515245 + 12345;
                a = int'((s >> 8) % 24001) - 12000;
                s = s * 1103515245 + 12345;
                b = int'((s >> 8) % 24001) - 12000;
                mem[i] = {16'(a), 16'(b)};
            end
        end
        run_block(DEPTH, "R2", 1'b0);

        // R4: imaginary 16384 gives bit 14, growth 2
        for (int i = 0; i < 4; i++) mem[i] = {16'(-i * 1000 - 5), 16'(i * 300)};
        mem[2][15:0] = 16'h4000;
        run_block(4, "R4", 1'b0);

        // R1: a mid-life reset clears the exponent
        rst_n = 1'b0;
        @(negedge clk);
        chk(expo == 0, "R1", "exponent cleared by reset", expo, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule